// File: doc/BRIEF.md
# Summed-Shift-Register Gaussian Noise Source

This block produces a stream of signed pseudo-random samples whose distribution is close to Gaussian. It is meant for noise injection in test datapaths. Several independent linear-feedback shift registers, each with its own length and feedback taps, advance together one step on every enabled clock. A fixed number of low bits is taken from each register as an unsigned value and the values are added. Because the sources are independent, their sum is bell-shaped by the central limit effect. Three sources give a rough Gaussian shape with no scaling multiplier, and more sources give a closer match.

The sum is re-centred by subtracting its mean, so the output is a signed value around zero. A seed port loads all registers at once. An all-zero seed slice is replaced by a nonzero constant, so no register can lock up. A valid flag marks each cycle that carries a fresh sample.

Top module: `gauss_noise_gen`

## Requirements
- R1: After a synchronous active-low reset, `sample_o` is 0 and `valid_o` is 0, and every shift register holds the value 1.
- R2: `valid_o` equals the value `en` had at the previous rising clock edge.
- R3: Source k (k = 0,1,2 by default) is a Fibonacci register of length L with tap T, where (L,T) is (17,14), (23,18) and (31,28). One step maps state s to {s[L-2:0], s[L-1] ^ s[T-1]}. A register steps only on an edge where `en` is 1 and `seed_load` is 0.
- R4: On an edge where `en` is 1, `sample_o` becomes the sum of bits [7:0] of each source's state before that edge, minus 382, as a signed 11-bit value.
- R5: While `en` is 0 and `seed_load` is 0, no source changes state and `sample_o` holds its value.
- R6: On an edge where `seed_load` is 1, source k loads `seed_val[L-1:0]`, using its own length L, in place of stepping.
- R7: If the loaded slice `seed_val[L-1:0]` is all zero, that source loads 1 instead.
- R8: `sample_o` always lies in the range -382 to +383.
- R9: When `seed_load` and `en` are both 1 on one edge, the sources take the seed. `sample_o` is formed from the state before the load, and `valid_o` becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance the sources and emit a sample |
| seed_load | input | 1 | Load all sources from `seed_val` |
| seed_val | input | 32 | Seed; each source takes its low L bits |
| sample_o | output | 11 | Signed, zero-centred noise sample |
| valid_o | output | 1 | High the cycle after an enabled edge |

## Verification
The two functions that can meet on one edge are a seed load and an enabled step. When both fall on the same edge, the load must win the register state, while the sample is still formed from the state before the load. The bench provokes this with directed cycles that raise both controls together, including all-zero seed slices, and with random cycles where they coincide by chance. A bench model of the shift registers judges each case: it applies the load after computing the expected sample. A mismatch then shows up either in that sample or in every sample that follows.

// File: rtl/gng_pkg.sv
// Package: shift-register lengths and taps for the noise sources.
// Assumes at most four sources; each entry is a maximal-length pair.
package gng_pkg;
    localparam int MAX_SRC = 4;
    localparam int SRC_LEN [MAX_SRC] = '{17, 23, 31, 29};
    localparam int SRC_TAP [MAX_SRC] = '{14, 18, 28, 27};
    localparam logic [31:0] ZERO_SUB = 32'd1;
endpackage

// File: rtl/lfsr_stage.sv
// One Fibonacci shift register of length LEN with feedback LEN xor TAP.
// Loads a seed slice (zero replaced by 1) with priority over stepping.
// Assumes SEED_W >= LEN and TAP < LEN.
module lfsr_stage #(
    parameter int LEN    = 17,
    parameter int TAP    = 14,
    parameter int SEED_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic [SEED_W-1:0] seed,
    output logic [LEN-1:0]    state_o
);
    logic [LEN-1:0] slice;
    logic [LEN-1:0] nxt;

    // Seed slice with the lock-up value swapped out
    always_comb begin
        slice = seed[LEN-1:0];
        if (slice == '0) slice = LEN'(gng_pkg::ZERO_SUB);
        nxt = {state_o[LEN-2:0], state_o[LEN-1] ^ state_o[TAP-1]};
    end

    // State register: reset, load, step or hold
    always_ff @(posedge clk) begin
        if (!rst_n)    state_o <= LEN'(1);
        else if (load) state_o <= slice;
        else if (step) state_o <= nxt;
    end

    // R7
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> state_o != '0);
    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !step |=> $stable(state_o));
endmodule

// File: rtl/noise_sum.sv
// Adds NBITS-bit slices from NSRC sources, subtracts the mean and
// registers the signed result together with a valid flag.
// Assumes the flat input holds source k in bits [k*NBITS +: NBITS].
module noise_sum #(
    parameter int NSRC  = 3,
    parameter int NBITS = 8,
    parameter int SW    = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [NSRC*NBITS-1:0]   bits_i,
    output logic signed [SW-1:0]    sample_o,
    output logic                    valid_o
);
    localparam int MAXSUM = NSRC * ((1 << NBITS) - 1);
    localparam int MEAN   = MAXSUM / 2;

    logic [SW-1:0] acc;

    // Unsigned sum of all slices, then re-centred
    always_comb begin
        acc = '0;
        for (int k = 0; k < NSRC; k++)
            acc = acc + SW'(bits_i[k*NBITS +: NBITS]);
        acc = acc - SW'(MEAN);
    end

    // Output register: capture on enable, valid tracks enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= en;
            if (en) sample_o <= $signed(acc);
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> valid_o);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !valid_o);
    // R5
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sample_o));
    // R8
    sample_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sample_o) >= -MEAN) && (int'(sample_o) <= MAXSUM - MEAN));
endmodule

// File: rtl/gauss_noise_gen.sv
// Top: NSRC shift registers of distinct length step together on enable;
// their low NBITS bits are summed and centred into a signed sample.
// Assumes NSRC <= 4 and SEED_W at least the longest register length.
module gauss_noise_gen #(
    parameter int NSRC   = 3,
    parameter int NBITS  = 8,
    parameter int SEED_W = 32,
    localparam int SW    = $clog2(NSRC * ((1 << NBITS) - 1) + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 seed_load,
    input  logic [SEED_W-1:0]    seed_val,
    output logic signed [SW-1:0] sample_o,
    output logic                 valid_o
);
    logic [NSRC*NBITS-1:0] bits_flat;
    logic                  step;

    // Loading takes priority over stepping
    assign step = en & ~seed_load;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam int L = gng_pkg::SRC_LEN[g];
        logic [L-1:0] st;

        lfsr_stage #(.LEN(L), .TAP(gng_pkg::SRC_TAP[g]), .SEED_W(SEED_W)) u_lfsr (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (step),
            .load   (seed_load),
            .seed   (seed_val),
            .state_o(st)
        );
        assign bits_flat[g*NBITS +: NBITS] = st[NBITS-1:0];

        // R6
        seed_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seed_load && (seed_val[L-1:0] != '0) |=> st == $past(seed_val[L-1:0]));
    end

    noise_sum #(.NSRC(NSRC), .NBITS(NBITS), .SW(SW)) u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .bits_i  (bits_flat),
        .sample_o(sample_o),
        .valid_o (valid_o)
    );
endmodule

// File: tb/sim_gauss_noise_gen.sv
module sim_gauss_noise_gen;
    localparam int MEAN = 382;
    localparam int LEN [3] = '{17, 23, 31};
    localparam int TAP [3] = '{14, 18, 28};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic seed_load = 1'b0;
    logic [31:0] seed_val = '0;
    logic signed [10:0] sample_o;
    logic valid_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] mst [3];
    int exp_s = 0;
    bit exp_v = 0;

    always #2.5 clk = ~clk;

    gauss_noise_gen u0 (.clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load),
                        .seed_val(seed_val), .sample_o(sample_o), .valid_o(valid_o));

    function automatic logic [31:0] step_m(logic [31:0] s, int l, int t);
        logic [31:0] m = (32'd1 << l) - 1;
        return ((s << 1) | 32'(s[l-1] ^ s[t-1])) & m;
    endfunction

    function automatic logic [31:0] seed_m(logic [31:0] sv, int l);
        logic [31:0] v = sv & ((32'd1 << l) - 1);
        return (v == 0) ? 32'd1 : v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive one cycle at negedge, update model, check at next negedge
    task automatic cyc(bit e, bit ld, logic [31:0] sv, string tag);
        en = e; seed_load = ld; seed_val = sv;
        if (e) begin
            exp_s = int'(mst[0][7:0]) + int'(mst[1][7:0]) + int'(mst[2][7:0]) - MEAN;
        end
        exp_v = e;
        for (int k = 0; k < 3; k++) begin
            if (ld) mst[k] = seed_m(sv, LEN[k]);
            else if (e) mst[k] = step_m(mst[k], LEN[k], TAP[k]);
        end
        @(negedge clk);
        chk({tag, " valid (R2)"}, int'(valid_o), int'(exp_v));
        chk({tag, " sample"}, int'(sample_o), exp_s);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) mst[k] = 32'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", int'(valid_o), 0);
        chk("R1 reset sample", int'(sample_o), 0);
        cyc(1, 0, 0, "R1 first sample from reset state");
        cyc(1, 0, 0, "R3 step");
        cyc(1, 0, 0, "R4 sum");
        // hold
        for (int i = 0; i < 8; i++) cyc(0, 0, 32'hFFFF_FFFF, "R5 idle");
        cyc(1, 0, 0, "R5 resume");
        // seed load alone, including zero slices
        cyc(0, 1, 32'h0000_0000, "R7 zero seed");
        cyc(1, 0, 0, "R7 after zero seed");
        cyc(0, 1, 32'h7F80_0000, "R7 partial zero");
        cyc(1, 0, 0, "R6 after seed");
        cyc(0, 1, 32'h1234_5678, "R6 load");
        cyc(1, 0, 0, "R6 first");
        // load and enable together
        cyc(1, 1, 32'hDEAD_BEEF, "R9 load+en");
        cyc(1, 0, 0, "R9 after");
        cyc(1, 1, 32'h0000_0000, "R9 zero load+en");
        cyc(1, 0, 0, "R9 after zero");
        // extremes of range
        cyc(0, 1, 32'hFFFF_FFFF, "R8 max seed");
        cyc(1, 0, 0, "R8 max sum");
        // random
        void'($urandom(32'd7781));
        for (int i = 0; i < 3000; i++) begin
            bit e = ($urandom_range(3) != 0);
            bit ld = ($urandom_range(19) == 0);
            logic [31:0] sv = $urandom();
            if ($urandom_range(7) == 0) sv = 32'h0;
            cyc(e, ld, sv, "R3/R4 random");
            if (int'(sample_o) < -382 || int'(sample_o) > 383)
                chk("R8 range", int'(sample_o), 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule